// File: doc/BRIEF.md
# Stalling Card Bus Bridge

This block connects a processor bus to an external card controller chip over a shared 16-bit bus. Each processor access carries a 2-bit space code. The code selects one of three card memory spaces or the controller's own registers. The block turns each access into a request phase and one or more data beats. While the access is in flight, the processor is held in a stall. The block ends that stall only when the last beat has completed.

The card controller signals availability on a ready pin. Before the block starts a card-space access, it waits for ready. It samples ready again at the end of a two-cycle request phase. If ready is still high, the data beats follow at once. If ready has gone low, the block drops chip select and withdraws its bus request. This lets another bus master, such as a display DMA engine, use the bus. When ready returns, the block asks the arbiter for the bus again and finishes the transfer. Register-space accesses never look at ready.

A mode input chooses what the ready pin does. In one mode it is the handshake. In the other it is a plain input bit, and the handshake is then treated as always ready.

Top module: `card_bridge_top`

## Requirements
- R1: After reset, cpu_stall, cpu_done, bus_req, card_cs, card_dphase and card_data_oe are all 0.
- R2: An access with space code 3 (controller registers) runs to completion with card_rdy_pin held low. Its chip select stays high for two request cycles plus its data beats, and it is not dropped in between.
- R3: For space codes 0, 1 and 2 in handshake mode, while card_rdy_pin is low before the request phase, neither bus_req nor card_cs is asserted.
- R4: If ready is high when sampled at the third clock edge of the request phase, the data beats follow immediately. card_cs stays high throughout, for 2 plus the number of beats cycles, with no release.
- R5: If ready is low at that edge, the block deasserts card_cs and bus_req. It keeps cpu_stall high for as long as ready stays low.
- R6: When ready returns after a release, the block asserts bus_req with card_cs low until bus_gnt is given. It then runs the data beats and completes.
- R7: cpu_stall is high from the cycle after an access is accepted until the completing cycle. In the completing cycle, cpu_done is high for one cycle and cpu_stall is low.
- R8: A byte access (cpu_byte=1) uses one data beat. A read returns bits [7:0] of the beat for an even address, or bits [15:8] for an odd address, zero-extended. A write drives the byte on both halves of card_data_out.
- R9: A 32-bit access (cpu_byte=0) uses two beats. The first beat, at the base address, carries bits [15:0]. The second, at the base address + 2, carries bits [31:16].
- R10: With ready_mode=0, card accesses proceed whatever the level of card_rdy_pin. In that mode gpio_value shows the pin one cycle later; with ready_mode=1, gpio_value holds its value.
- R11: Read data appears on cpu_rdata in the cycle in which cpu_done is high.
- R12: While an access is in flight, the block uses the address, space code, direction and write data captured when the access was accepted. Changes on the processor inputs have no effect until the access completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, accepted while idle |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_byte | input | 1 | 1 = byte access, 0 = 32-bit access |
| cpu_space | input | 2 | Space code: 0 attribute, 1 I/O, 2 common, 3 controller registers |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | CPU_DW | Write data |
| cpu_stall | output | 1 | Processor held while high |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | CPU_DW | Read data, valid with cpu_done |
| bus_req | output | 1 | Request to the bus arbiter |
| bus_gnt | input | 1 | Grant from the bus arbiter |
| card_cs | output | 1 | Chip select to the card controller |
| card_dphase | output | 1 | High during data beats |
| card_we | output | 1 | Direction of the current access |
| card_space | output | 2 | Space code of the current access |
| card_addr | output | ADDR_W | Address of the current beat |
| card_data_out | output | 16 | Write data of the current beat |
| card_data_oe | output | 1 | Write data drive enable |
| card_data_in | input | 16 | Read data from the card bus |
| card_rdy_pin | input | 1 | Ready pin, or a general input bit |
| ready_mode | input | 1 | 1 = pin is the ready handshake, 0 = general input |
| gpio_value | output | 1 | Captured pin value in general-input mode |

## Verification
The bench pulls ready low in the cycle just before the third request edge. A bridge that samples ready one edge late or early would either run the data beats or fail to release, and the chip select and bus request counts would show it. It also holds ready low during register-space accesses, and a bridge that gated those on ready would hang until the bench times out. During a split transfer it withholds the grant after ready returns, which would expose a bridge that drove chip select without owning the bus. It also scrambles the processor address and data right after acceptance: a bridge that did not hold the captured access would write wrong words or beat addresses.

// File: rtl/card_bridge_pkg.sv
package card_bridge_pkg;
  localparam int BUS_DW = 16;

  localparam logic [1:0] SPC_ATTR   = 2'd0;
  localparam logic [1:0] SPC_IO     = 2'd1;
  localparam logic [1:0] SPC_COMMON = 2'd2;
  localparam logic [1:0] SPC_REGS   = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARB,
    ST_REQ1,
    ST_REQ2,
    ST_PARK,
    ST_REARB,
    ST_DATA,
    ST_DONE
  } seq_state_t;
endpackage

// File: rtl/cb_ready_if.sv
module cb_ready_if (
  input  logic clk,
  input  logic rst,
  input  logic ready_mode,
  input  logic card_rdy_pin,
  output logic rdy_ok,
  output logic gpio_value
);
  // In general-input mode the handshake is treated as permanently ready.
  assign rdy_ok = ready_mode ? card_rdy_pin : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      gpio_value <= 1'b0;
    end else if (!ready_mode) begin
      gpio_value <= card_rdy_pin;
    end
  end
endmodule

// File: rtl/cb_txn.sv
module cb_txn
  import card_bridge_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CPU_DW = 32,
  parameter int BEATS  = CPU_DW / BUS_DW,
  parameter int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               cap,
  input  logic [BEAT_W-1:0]  beat,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [1:0]         cpu_space,
  input  logic               cpu_write,
  input  logic               cpu_byte,
  input  logic [CPU_DW-1:0]  cpu_wdata,
  input  logic [BUS_DW-1:0]  card_data_in,
  output logic               txn_is_reg,
  output logic               txn_byte,
  output logic [ADDR_W-1:0]  card_addr,
  output logic [1:0]         card_space,
  output logic               card_we,
  output logic [BUS_DW-1:0]  card_data_out,
  output logic [CPU_DW-1:0]  cpu_rdata
);
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        space_q;
  logic              we_q;
  logic              byte_q;
  logic [CPU_DW-1:0] wdata_q;

  logic [BUS_DW-1:0] wr_half [BEATS];
  logic [BUS_DW-1:0] rd_half [BEATS];

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      space_q <= SPC_ATTR;
      we_q    <= 1'b0;
      byte_q  <= 1'b0;
      wdata_q <= '0;
    end else if (load) begin
      addr_q  <= cpu_addr;
      space_q <= cpu_space;
      we_q    <= cpu_write;
      byte_q  <= cpu_byte;
      wdata_q <= cpu_wdata;
    end
  end

  for (genvar b = 0; b < BEATS; b++) begin : g_beat
    assign wr_half[b] = wdata_q[b*BUS_DW +: BUS_DW];

    always_ff @(posedge clk) begin
      if (rst) begin
        rd_half[b] <= '0;
      end else if (cap && (beat == BEAT_W'(b))) begin
        rd_half[b] <= card_data_in;
      end
    end

    assign cpu_rdata[b*BUS_DW +: BUS_DW] =
      byte_q ? ((b == 0) ? {8'h00, (addr_q[0] ? rd_half[0][15:8] : rd_half[0][7:0])}
                         : {BUS_DW{1'b0}})
             : rd_half[b];
  end

  assign txn_is_reg    = (space_q == SPC_REGS);
  assign txn_byte      = byte_q;
  assign card_space    = space_q;
  assign card_we       = we_q;
  assign card_addr     = addr_q + (ADDR_W'(beat) << 1);
  assign card_data_out = byte_q ? {wdata_q[7:0], wdata_q[7:0]} : wr_half[beat];
endmodule

// File: rtl/cb_seq.sv
module cb_seq
  import card_bridge_pkg::*;
#(
  parameter int BEATS  = 2,
  parameter int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              txn_is_reg,
  input  logic              txn_byte,
  input  logic              txn_we,
  input  logic              rdy_ok,
  input  logic              bus_gnt,
  output logic              load,
  output logic              cap,
  output logic [BEAT_W-1:0] beat,
  output logic              cpu_stall,
  output logic              cpu_done,
  output logic              bus_req,
  output logic              card_cs,
  output logic              card_dphase,
  output logic              card_data_oe
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  seq_state_t        state_q, state_n;
  logic [BEAT_W-1:0] beat_q, beat_n;
  logic              last_beat;
  logic              may_start;

  assign last_beat = txn_byte || (beat_q == LAST_BEAT);
  // Register space ignores ready; card spaces need ready before the request.
  assign may_start = txn_is_reg || rdy_ok;

  always_comb begin
    state_n = state_q;
    beat_n  = beat_q;
    unique case (state_q)
      ST_IDLE: begin
        beat_n = '0;
        if (cpu_req) state_n = ST_ARB;
      end
      ST_ARB:   if (may_start && bus_gnt) state_n = ST_REQ1;
      ST_REQ1:  state_n = ST_REQ2;
      ST_REQ2:  state_n = may_start ? ST_DATA : ST_PARK;
      ST_PARK:  if (rdy_ok) state_n = ST_REARB;
      ST_REARB: if (bus_gnt) state_n = ST_DATA;
      ST_DATA: begin
        if (last_beat) begin
          state_n = ST_DONE;
        end else begin
          beat_n = beat_q + 1'b1;
        end
      end
      ST_DONE:  state_n = ST_IDLE;
      default:  state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_n;
      beat_q  <= beat_n;
    end
  end

  assign load         = (state_q == ST_IDLE) && cpu_req;
  assign cap          = (state_q == ST_DATA) && !txn_we;
  assign beat         = beat_q;
  assign cpu_stall    = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign cpu_done     = (state_q == ST_DONE);
  assign card_cs      = (state_q == ST_REQ1) || (state_q == ST_REQ2) || (state_q == ST_DATA);
  assign card_dphase  = (state_q == ST_DATA);
  assign card_data_oe = (state_q == ST_DATA) && txn_we;
  assign bus_req      = ((state_q == ST_ARB) && may_start) || (state_q == ST_REARB) || card_cs;
endmodule

// File: rtl/card_bridge_top.sv
module card_bridge_top
  import card_bridge_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CPU_DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_write,
  input  logic              cpu_byte,
  input  logic [1:0]        cpu_space,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [CPU_DW-1:0] cpu_wdata,
  output logic              cpu_stall,
  output logic              cpu_done,
  output logic [CPU_DW-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              card_cs,
  output logic              card_dphase,
  output logic              card_we,
  output logic [1:0]        card_space,
  output logic [ADDR_W-1:0] card_addr,
  output logic [15:0]       card_data_out,
  output logic              card_data_oe,
  input  logic [15:0]       card_data_in,
  input  logic              card_rdy_pin,
  input  logic              ready_mode,
  output logic              gpio_value
);
  localparam int BEATS  = CPU_DW / BUS_DW;
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic              rdy_ok;
  logic              load;
  logic              cap;
  logic [BEAT_W-1:0] beat;
  logic              txn_is_reg;
  logic              txn_byte;

  cb_ready_if u_rdy (
    .clk          (clk),
    .rst          (rst),
    .ready_mode   (ready_mode),
    .card_rdy_pin (card_rdy_pin),
    .rdy_ok       (rdy_ok),
    .gpio_value   (gpio_value)
  );

  cb_seq #(.BEATS(BEATS), .BEAT_W(BEAT_W)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .cpu_req      (cpu_req),
    .txn_is_reg   (txn_is_reg),
    .txn_byte     (txn_byte),
    .txn_we       (card_we),
    .rdy_ok       (rdy_ok),
    .bus_gnt      (bus_gnt),
    .load         (load),
    .cap          (cap),
    .beat         (beat),
    .cpu_stall    (cpu_stall),
    .cpu_done     (cpu_done),
    .bus_req      (bus_req),
    .card_cs      (card_cs),
    .card_dphase  (card_dphase),
    .card_data_oe (card_data_oe)
  );

  cb_txn #(.ADDR_W(ADDR_W), .CPU_DW(CPU_DW), .BEATS(BEATS), .BEAT_W(BEAT_W)) u_txn (
    .clk           (clk),
    .rst           (rst),
    .load          (load),
    .cap           (cap),
    .beat          (beat),
    .cpu_addr      (cpu_addr),
    .cpu_space     (cpu_space),
    .cpu_write     (cpu_write),
    .cpu_byte      (cpu_byte),
    .cpu_wdata     (cpu_wdata),
    .card_data_in  (card_data_in),
    .txn_is_reg    (txn_is_reg),
    .txn_byte      (txn_byte),
    .card_addr     (card_addr),
    .card_space    (card_space),
    .card_we       (card_we),
    .card_data_out (card_data_out),
    .cpu_rdata     (cpu_rdata)
  );
endmodule

// File: rtl/cb_checker.sv
module cb_checker (
  input logic       clk,
  input logic       rst,
  input logic       cpu_stall,
  input logic       cpu_done,
  input logic       bus_req,
  input logic       card_cs,
  input logic       card_dphase,
  input logic       card_we,
  input logic [1:0] card_space,
  input logic       card_data_oe,
  input logic       card_rdy_pin,
  input logic       ready_mode
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!cpu_stall && !cpu_done && !bus_req && !card_cs)); // R1

  AST_START_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
    ($rose(card_cs) && !card_dphase && card_space != 2'd3 && ready_mode)
      |-> $past(card_rdy_pin)); // R3

  AST_RELEASE_DROPS_REQ: assert property (@(posedge clk) disable iff (rst)
    ($fell(card_cs) && cpu_stall) |-> !bus_req); // R5

  AST_CS_OWNS_BUS: assert property (@(posedge clk) disable iff (rst)
    card_cs |-> bus_req); // R6

  AST_DONE_UNSTALLED: assert property (@(posedge clk) disable iff (rst)
    cpu_done |-> (!cpu_stall && $past(cpu_stall))); // R7

  AST_TXN_HELD: assert property (@(posedge clk) disable iff (rst)
    (cpu_stall && $past(cpu_stall)) |-> ($stable(card_space) && $stable(card_we))); // R12

  AST_DRIVE_IN_BEAT: assert property (@(posedge clk) disable iff (rst)
    card_data_oe |-> (card_cs && card_dphase && card_we)); // R9
endmodule

bind card_bridge_top cb_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .cpu_stall    (cpu_stall),
  .cpu_done     (cpu_done),
  .bus_req      (bus_req),
  .card_cs      (card_cs),
  .card_dphase  (card_dphase),
  .card_we      (card_we),
  .card_space   (card_space),
  .card_data_oe (card_data_oe),
  .card_rdy_pin (card_rdy_pin),
  .ready_mode   (ready_mode)
);

// File: tb/card_bridge_top_tb.sv
module card_bridge_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0, cpu_write = 1'b0, cpu_byte = 1'b0;
  logic [1:0]  cpu_space = 2'd0;
  logic [23:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_stall, cpu_done;
  logic [31:0] cpu_rdata;
  logic        bus_req, bus_gnt;
  logic        gnt_en = 1'b1;
  logic        card_cs, card_dphase, card_we, card_data_oe;
  logic [1:0]  card_space;
  logic [23:0] card_addr;
  logic [15:0] card_data_out, card_data_in;
  logic        card_rdy_pin = 1'b1;
  logic        ready_mode = 1'b1;
  logic        gpio_value;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;

  int cs_cnt, drop_cnt, log_n, stall_gap;
  logic [23:0] log_addr [8];
  logic [15:0] log_data [8];
  logic        prev_cs = 1'b0;

  function automatic logic [15:0] mdl(input logic [23:0] a);
    return a[15:0] ^ 16'hC35A;
  endfunction

  assign card_data_in = mdl(card_addr);
  assign bus_gnt      = bus_req && gnt_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  card_bridge_top u_dut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_write(cpu_write), .cpu_byte(cpu_byte),
    .cpu_space(cpu_space), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_stall(cpu_stall), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .card_cs(card_cs), .card_dphase(card_dphase),
    .card_we(card_we), .card_space(card_space), .card_addr(card_addr),
    .card_data_out(card_data_out), .card_data_oe(card_data_oe), .card_data_in(card_data_in),
    .card_rdy_pin(card_rdy_pin), .ready_mode(ready_mode), .gpio_value(gpio_value)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (card_cs) cs_cnt <= cs_cnt + 1;
    if (prev_cs && !card_cs && cpu_stall) drop_cnt <= drop_cnt + 1;
    prev_cs <= card_cs;
    if (card_cs && card_dphase && card_we && log_n < 8) begin
      log_addr[log_n] <= card_addr;
      log_data[log_n] <= card_data_out;
      log_n <= log_n + 1;
    end
    if (cyc == WATCHDOG && !finished) begin
      finished = 1;
      failures = failures + 1;
      checks = checks + 1;
      $display("FAIL watchdog act=%0d exp<%0d", cyc, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(negedge clk);
    cs_cnt = 0; drop_cnt = 0; log_n = 0; stall_gap = 0;
  endtask

  task automatic start_access(input bit wr, input logic [1:0] sp, input logic [23:0] a,
                              input logic [31:0] wd, input bit byt);
    clear_mon();
    cpu_write = wr; cpu_space = sp; cpu_addr = a; cpu_wdata = wd; cpu_byte = byt;
    cpu_req = 1'b1;
    @(negedge clk);
    cpu_req = 1'b0;
    // scramble the processor inputs: the captured access must be used (R12)
    cpu_addr = ~a; cpu_wdata = 32'hDEAD_BEEF; cpu_space = ~sp; cpu_write = ~wr;
    check(cpu_stall == 1'b1, "R7", "stall after accept", {31'd0, cpu_stall}, 32'd1);
  endtask

  task automatic finish_access(output logic [31:0] rd, output int lat);
    lat = 0;
    while (!cpu_done && lat < 300) begin
      if (!cpu_stall) stall_gap++;
      @(negedge clk);
      lat++;
    end
    rd = cpu_rdata;
    check(cpu_done && !cpu_stall && stall_gap == 0, "R7", "stall held then done",
          {cpu_done, cpu_stall, 30'(stall_gap)}, 32'h8000_0000);
    @(negedge clk);
    check(!cpu_done, "R7", "done is one cycle", {31'd0, cpu_done}, 32'd0);
  endtask

  // Drop ready just before the decision edge of the request phase, park, then re-arbitrate.
  task automatic split_middle();
    int bad;
    int guard;
    guard = 0;
    while (!card_cs && guard < 50) begin @(negedge clk); guard++; end
    @(negedge clk);
    card_rdy_pin = 1'b0; gnt_en = 1'b0;
    bad = 0;
    repeat (6) begin
      @(negedge clk);
      if (card_cs || bus_req || !cpu_stall) bad++;
    end
    check(bad == 0, "R5", "parked while ready low", 32'(bad), 32'd0);
    card_rdy_pin = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(bus_req && !card_cs && cpu_stall, "R6", "re-request without grant",
          {29'd0, bus_req, card_cs, cpu_stall}, 32'h5);
    gnt_en = 1'b1;
  endtask

  task automatic t_reset();
    check(!cpu_stall && !cpu_done && !bus_req && !card_cs && !card_dphase && !card_data_oe,
          "R1", "outputs in reset",
          {26'd0, cpu_stall, cpu_done, bus_req, card_cs, card_dphase, card_data_oe}, 32'd0);
  endtask

  task automatic t_reg_space();
    logic [31:0] rd; int lat;
    card_rdy_pin = 1'b0;
    start_access(1'b0, 2'd3, 24'h000010, 32'h0, 1'b1);
    finish_access(rd, lat);
    check(cs_cnt == 3 && drop_cnt == 0, "R2", "register access ignores ready",
          {16'(cs_cnt), 16'(drop_cnt)}, {16'd3, 16'd0});
    check(rd == {24'd0, mdl(24'h000010)[7:0]}, "R11", "register byte read", rd,
          {24'd0, mdl(24'h000010)[7:0]});
    card_rdy_pin = 1'b1;
  endtask

  task automatic t_combined_byte_read();
    logic [31:0] rd; int lat;
    start_access(1'b0, 2'd2, 24'h000123, 32'h0, 1'b1);
    finish_access(rd, lat);
    check(cs_cnt == 3 && drop_cnt == 0, "R4", "combined cycle chip select",
          {16'(cs_cnt), 16'(drop_cnt)}, {16'd3, 16'd0});
    check(rd == {24'd0, mdl(24'h000123)[15:8]}, "R8", "odd byte lane read", rd,
          {24'd0, mdl(24'h000123)[15:8]});
  endtask

  task automatic t_wait_before_start();
    logic [31:0] rd; int lat; int bad;
    card_rdy_pin = 1'b0;
    start_access(1'b0, 2'd0, 24'h000040, 32'h0, 1'b1);
    bad = 0;
    repeat (8) begin
      @(negedge clk);
      if (bus_req || card_cs) bad++;
    end
    check(bad == 0, "R3", "no request while busy", 32'(bad), 32'd0);
    card_rdy_pin = 1'b1;
    finish_access(rd, lat);
    check(rd == {24'd0, mdl(24'h000040)[7:0]} && cs_cnt == 3, "R3", "completes after ready",
          rd, {24'd0, mdl(24'h000040)[7:0]});
  endtask

  task automatic t_split_word_read();
    logic [31:0] rd, exp; int lat;
    start_access(1'b0, 2'd1, 24'h000400, 32'h0, 1'b0);
    split_middle();
    finish_access(rd, lat);
    exp = {mdl(24'h000402), mdl(24'h000400)};
    check(rd == exp, "R9", "split word read data", rd, exp);
    check(cs_cnt == 4 && drop_cnt == 1, "R6", "split then two beats",
          {16'(cs_cnt), 16'(drop_cnt)}, {16'd4, 16'd1});
  endtask

  task automatic t_split_word_write();
    logic [31:0] rd; int lat;
    start_access(1'b1, 2'd0, 24'h000800, 32'h1234_ABCD, 1'b0);
    split_middle();
    finish_access(rd, lat);
    check(log_n == 2, "R9", "word write beats", 32'(log_n), 32'd2);
    check(log_addr[0] == 24'h000800 && log_data[0] == 16'hABCD, "R12", "first beat held",
          {log_addr[0][15:0], log_data[0]}, {16'h0800, 16'hABCD});
    check(log_addr[1] == 24'h000802 && log_data[1] == 16'h1234, "R9", "second beat",
          {log_addr[1][15:0], log_data[1]}, {16'h0802, 16'h1234});
  endtask

  task automatic t_byte_write();
    logic [31:0] rd; int lat;
    start_access(1'b1, 2'd2, 24'h000011, 32'h0000_005E, 1'b1);
    finish_access(rd, lat);
    check(log_n == 1 && log_data[0] == 16'h5E5E, "R8", "byte write one beat both lanes",
          {16'(log_n), log_data[0]}, {16'd1, 16'h5E5E});
  endtask

  task automatic t_gpio_mode();
    logic [31:0] rd; int lat;
    ready_mode = 1'b0; card_rdy_pin = 1'b0;
    start_access(1'b0, 2'd2, 24'h000202, 32'h0, 1'b1);
    finish_access(rd, lat);
    check(cs_cnt == 3 && rd == {24'd0, mdl(24'h000202)[7:0]}, "R10",
          "access ignores pin in input mode", rd, {24'd0, mdl(24'h000202)[7:0]});
    card_rdy_pin = 1'b1;
    @(negedge clk);
    check(gpio_value == 1'b1, "R10", "pin high captured", {31'd0, gpio_value}, 32'd1);
    card_rdy_pin = 1'b0;
    @(negedge clk);
    check(gpio_value == 1'b0, "R10", "pin low captured", {31'd0, gpio_value}, 32'd0);
    ready_mode = 1'b1; card_rdy_pin = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(gpio_value == 1'b0, "R10", "value held in handshake mode", {31'd0, gpio_value}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reg_space();
    t_combined_byte_read();
    t_wait_before_start();
    t_split_word_read();
    t_split_word_write();
    t_byte_write();
    t_gpio_mode();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule